// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block performs the AES-128 forward cipher at full rate. It takes one 128-bit plaintext block and one 128-bit key on every rising clock edge. After a fixed delay it returns the matching 128-bit ciphertext. The ten rounds are unrolled into a chain of register stages. Each block's round key is expanded inside the same chain and moves along beside that block's state. Consecutive blocks may therefore use unrelated keys, and no key is ever loaded ahead of time.

Each round merges byte substitution and row shifting into one step. The key expansion for a round is split across two neighbouring stages. The word function of the schedule (rotate, substitute, round constant) is computed in the stage that performs the previous round's key addition, and its result is registered. The next stage then folds it through the XOR chain over the four key columns, in parallel with its own substitution and shift.

Top module: `aes128_pipe`

## Requirements
- R1: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: A new plaintext/key pair is accepted on every rising edge, and every output equals the AES-128 encryption of its own pair, with no gaps between blocks.
- R3: A pair sampled at rising edge k appears on `cipherOut` right after rising edge k+11, so the total delay is 12 edges, and not earlier.
- R4: While `rst` is high, every stage register and `cipherOut` are zero. The clear takes effect at once, without waiting for a clock edge.
- R5: Byte 0 is bits [127:120] of each 128-bit vector, and bytes fill the state column by column. With key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, the output is 3925841d02dc09fbdc118597196a0b32.
- R6: The first stage after the input register holds plaintext XOR key of the pair sampled one edge earlier.
- R7: Round keys follow the AES-128 schedule for each block's own key. Blocks back to back with the same plaintext and different keys give independent, correct ciphertexts, and each stage's key obeys the column-chain relation with the previous stage's key.
- R8: The last round leaves out column mixing. An all-zero key and an all-zero plaintext give 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R9: When the inputs are held constant for at least 12 edges, `cipherOut` stays constant and equals the encryption of the held pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Sampling and output updates happen on the rising edge. |
| rst | input | 1 | Asynchronous reset, active high. Clears all stage registers and the output. |
| plainIn | input | 128 | Plaintext block. Byte 0 is in the top bits. |
| keyIn | input | 128 | Cipher key for this block. Byte 0 is in the top bits. |
| cipherOut | output | 128 | Ciphertext of the pair sampled 12 edges earlier. |

## Verification
In every cycle, each stage finishes one block's key expansion and starts the word function for the following round, while the neighbouring stages work on blocks with different keys. The two functions that fall into the same cycle are therefore key expansion for one block and the data rounds of another. This overlap is provoked by streaming a new pair on every edge, including runs where the plaintext repeats but the key changes, so a key leaking between stages would corrupt a neighbour's output. Each output is compared with a bench model of the cipher, 12 edges after its pair was driven. An asynchronous reset in the middle of the stream, followed by a fresh stream, checks that the clear and the restart work together.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BLK_W      = 128;
  localparam int WORD_W     = 32;
  localparam int NUM_BYTES  = BLK_W / 8;
  localparam int NUM_COLS   = BLK_W / WORD_W;
  localparam int NUM_ROUNDS = 10;
  localparam int PIPE_LAT   = NUM_ROUNDS + 2;  // input register + whitening stage + rounds

  typedef logic [7:0]        byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BLK_W-1:0]  block_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gfMul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // substitution: inverse as x^254, then the affine map
  function automatic byte_t subByte(input byte_t x);
    byte_t sq;
    byte_t inv;
    sq  = gfMul(x, x);
    inv = sq;
    for (int i = 0; i < 6; i++) begin
      sq  = gfMul(sq, sq);
      inv = gfMul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t roundConst(input int rnd);
    byte_t c;
    c = 8'h01;
    for (int i = 1; i < rnd; i++) c = xtime(c);
    return c;
  endfunction

  // schedule word function applied to the last key column
  function automatic word_t wordFn(input word_t w, input byte_t rc);
    return {subByte(w[23:16]) ^ rc, subByte(w[15:8]), subByte(w[7:0]), subByte(w[31:24])};
  endfunction
endpackage

// File: rtl/aes_mix_col.sv
module aes_mix_col
  import aes_pkg::*;
(
  input  word_t colIn,
  output word_t colOut
);
  byte_t a0, a1, a2, a3;
  assign {a0, a1, a2, a3} = colIn;

  always_comb begin
    colOut[31:24] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    colOut[23:16] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    colOut[15:8]  = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    colOut[7:0]   = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end
endmodule

// File: rtl/aes_key_chain.sv
module aes_key_chain
  import aes_pkg::*;
(
  input  block_t prevKey,
  input  word_t  fword,
  output block_t nextKey
);
  word_t col [NUM_COLS];

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    if (c == 0) begin : g_head
      assign col[c] = fword ^ prevKey[BLK_W-1 -: WORD_W];
    end else begin : g_tail
      assign col[c] = col[c-1] ^ prevKey[BLK_W-1-WORD_W*c -: WORD_W];
    end
    assign nextKey[BLK_W-1-WORD_W*c -: WORD_W] = col[c];
  end
endmodule

// File: rtl/aes_round_stage.sv
module aes_round_stage
  import aes_pkg::*;
#(
  parameter bit          FINAL_RND = 1'b0,
  parameter logic [7:0]  NEXT_RCON = 8'h00
) (
  input  logic   clk,
  input  logic   rst,
  input  block_t stateIn,
  input  block_t keyIn,
  input  word_t  fwordIn,
  output block_t stateOut,
  output block_t keyOut,
  output word_t  fwordOut
);
  block_t shifted;
  block_t mixed;
  block_t nextKey;
  word_t  nextFw;

  // combined substitution and row shift
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
    localparam int ROW = i % 4;
    localparam int SRC = ROW + 4 * (((i / 4) + ROW) % NUM_COLS);
    assign shifted[BLK_W-1-8*i -: 8] = subByte(stateIn[BLK_W-1-8*SRC -: 8]);
  end

  // second half of key expansion, alongside substitution
  aes_key_chain u_chain (
    .prevKey(keyIn),
    .fword  (fwordIn),
    .nextKey(nextKey)
  );

  if (FINAL_RND) begin : g_last
    assign mixed  = shifted;
    assign nextFw = '0;
  end else begin : g_mid
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_mix
      aes_mix_col u_mix (
        .colIn (shifted[BLK_W-1-WORD_W*c -: WORD_W]),
        .colOut(mixed[BLK_W-1-WORD_W*c -: WORD_W])
      );
    end
    // first half of next round's expansion, alongside key addition
    assign nextFw = wordFn(nextKey[WORD_W-1:0], NEXT_RCON);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateOut <= '0;
      keyOut   <= '0;
      fwordOut <= '0;
    end else begin
      stateOut <= mixed ^ nextKey;
      keyOut   <= nextKey;
      fwordOut <= nextFw;
    end
  end
endmodule

// File: rtl/aes128_pipe.sv
module aes128_pipe
  import aes_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [127:0] plainIn,
  input  logic [127:0] keyIn,
  output logic [127:0] cipherOut
);
  block_t inPlain, inKey;
  block_t whitenState, whitenKey;
  word_t  whitenFw;

  block_t stageState [NUM_ROUNDS+1];
  block_t stageKey   [NUM_ROUNDS+1];
  word_t  stageFw    [NUM_ROUNDS+1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      inPlain     <= '0;
      inKey       <= '0;
      whitenState <= '0;
      whitenKey   <= '0;
      whitenFw    <= '0;
    end else begin
      inPlain     <= plainIn;
      inKey       <= keyIn;
      whitenState <= inPlain ^ inKey;
      whitenKey   <= inKey;
      whitenFw    <= wordFn(inKey[WORD_W-1:0], roundConst(1));
    end
  end

  assign stageState[0] = whitenState;
  assign stageKey[0]   = whitenKey;
  assign stageFw[0]    = whitenFw;

  for (genvar r = 1; r <= NUM_ROUNDS; r++) begin : g_rnd
    aes_round_stage #(
      .FINAL_RND(r == NUM_ROUNDS),
      .NEXT_RCON(roundConst(r + 1))
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .stateIn (stageState[r-1]),
      .keyIn   (stageKey[r-1]),
      .fwordIn (stageFw[r-1]),
      .stateOut(stageState[r]),
      .keyOut  (stageKey[r]),
      .fwordOut(stageFw[r])
    );
  end

  assign cipherOut = stageState[NUM_ROUNDS];
endmodule

// File: rtl/aes128_pipe_chk.sv
module aes128_pipe_chk
  import aes_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input block_t plainIn,
  input block_t keyIn,
  input block_t cipherOut,
  input block_t whiten,
  input block_t keyA,
  input block_t keyB,
  input word_t  lastFw
);
  localparam int CNT_MAX = PIPE_LAT + 3;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] sinceRst, holdCnt;
  block_t prevPlain, prevKey;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sinceRst  <= '0;
      holdCnt   <= '0;
      prevPlain <= '0;
      prevKey   <= '0;
    end else begin
      if (sinceRst != CNT_W'(CNT_MAX)) sinceRst <= sinceRst + 1'b1;
      prevPlain <= plainIn;
      prevKey   <= keyIn;
      if (sinceRst != '0 && plainIn == prevPlain && keyIn == prevKey) begin
        if (holdCnt != CNT_W'(CNT_MAX)) holdCnt <= holdCnt + 1'b1;
      end else begin
        holdCnt <= '0;
      end
    end
  end

  assert_reset_clear_R4: assert property (@(posedge clk) rst |-> (cipherOut == '0 && whiten == '0));

  assert_whiten_R6: assert property (@(posedge clk) disable iff (rst)
    sinceRst >= CNT_W'(2) |-> whiten == $past(plainIn ^ keyIn, 2));

  assert_key_chain_R7: assert property (@(posedge clk) disable iff (rst)
    sinceRst >= CNT_W'(1) |-> (keyB[95:64] ^ keyB[127:96]) == $past(keyA[95:64]));

  assert_final_no_fw_R8: assert property (@(posedge clk) disable iff (rst)
    sinceRst >= CNT_W'(1) |-> lastFw == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (holdCnt >= CNT_W'(PIPE_LAT) && sinceRst >= CNT_W'(PIPE_LAT + 1)) |-> $stable(cipherOut));
endmodule

bind aes128_pipe aes128_pipe_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .plainIn  (plainIn),
  .keyIn    (keyIn),
  .cipherOut(cipherOut),
  .whiten   (whitenState),
  .keyA     (stageKey[aes_pkg::NUM_ROUNDS-1]),
  .keyB     (stageKey[aes_pkg::NUM_ROUNDS]),
  .lastFw   (stageFw[aes_pkg::NUM_ROUNDS])
);

// File: tb/sim_aes128_pipe.sv
`timescale 1ns/1ps
module sim_aes128_pipe;
  localparam int LAT   = 12;
  localparam int NVEC  = 160;
  localparam int NTAIL = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b0;
  logic [127:0] plainIn = '0;
  logic [127:0] keyIn = '0;
  logic [127:0] cipherOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  logic [7:0]   sbTab [256];
  logic [127:0] vPt  [NVEC];
  logic [127:0] vKey [NVEC];
  logic [127:0] vExp [NVEC];
  string        vReq [NVEC];
  logic [63:0]  rngState = 64'h9e3779b97f4a7c15;

  always #2.5 clk = ~clk;

  aes128_pipe u0 (.clk(clk), .rst(rst), .plainIn(plainIn), .keyIn(keyIn), .cipherOut(cipherOut));

  function automatic logic [7:0] dbl(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] slowMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    p = '0;
    for (int i = 7; i >= 0; i--) begin
      p = dbl(p);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  // build the substitution table by searching for inverses
  task automatic buildTable();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      logic [7:0] o;
      inv = '0;
      for (int y = 1; y < 256; y++)
        if (x != 0 && slowMul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int b = 0; b < 8; b++)
        o[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 1);
      sbTab[x] = o;
    end
  endtask

  function automatic logic [127:0] refEncrypt(input logic [127:0] pt, input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [7:0]  rc;
    logic [31:0] tmp;
    logic [127:0] res;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sbTab[tmp[23:16]], sbTab[tmp[15:8]], sbTab[tmp[7:0]], sbTab[tmp[31:24]]} ^ {rc, 24'h0};
        rc = dbl(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) t[i] = sbTab[s[(i%4) + 4*(((i/4) + (i%4)) % 4)]];
      if (rd < 10) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a [4];
          for (int k = 0; k < 4; k++) a[k] = t[4*c+k];
          for (int k = 0; k < 4; k++)
            t[4*c+k] = slowMul(a[k], 8'h02) ^ slowMul(a[(k+1)%4], 8'h03) ^ a[(k+2)%4] ^ a[(k+3)%4];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ w[4*rd + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic nextRand(output logic [127:0] v);
    for (int h = 0; h < 2; h++) begin
      rngState = rngState ^ (rngState << 13);
      rngState = rngState ^ (rngState >> 7);
      rngState = rngState ^ (rngState << 17);
      v[64*h +: 64] = rngState;
    end
  endtask

  task automatic checkEq(input string req, input logic [127:0] act, input logic [127:0] expv);
    checkCnt++;
    if (act !== expv) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic runStream(input int count);
    for (int n = 0; n < count + LAT; n++) begin
      if (n >= LAT) checkEq(vReq[n-LAT], cipherOut, vExp[n-LAT]);
      if (n == LAT - 1) begin
        checkCnt++;
        if (cipherOut === vExp[0]) begin
          failCnt++;
          $display("FAIL R3 actual=%h expected=not %h (one edge early)", cipherOut, vExp[0]);
        end
      end
      if (n < count) begin
        plainIn = vPt[n];
        keyIn   = vKey[n];
      end
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    buildTable();
    // known answers use literal expected values
    vPt[0] = 128'h00112233445566778899aabbccddeeff; vKey[0] = 128'h000102030405060708090a0b0c0d0e0f;
    vExp[0] = 128'h69c4e0d86a7b0430d8cdb78070b4c55a; vReq[0] = "R1";
    vPt[1] = 128'h3243f6a8885a308d313198a2e0370734; vKey[1] = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    vExp[1] = 128'h3925841d02dc09fbdc118597196a0b32; vReq[1] = "R5";
    vPt[2] = '0; vKey[2] = '0;
    vExp[2] = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e; vReq[2] = "R8";
    for (int n = 3; n < NVEC; n++) begin
      logic [127:0] r;
      nextRand(r);
      vKey[n] = r;
      if (n % 4 == 0) begin
        vPt[n]  = vPt[n-1];  // same plaintext, fresh key
        vReq[n] = "R7";
      end else begin
        nextRand(r);
        vPt[n]  = r;
        vReq[n] = "R2";
      end
      vExp[n] = refEncrypt(vPt[n], vKey[n]);
    end

    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R4", cipherOut, '0);
    rst = 1'b0;
    runStream(NVEC);

    // held inputs: output stays equal to the held pair's ciphertext
    plainIn = vPt[1] ^ vKey[7];
    keyIn   = vKey[9];
    for (int n = 0; n < LAT + 8; n++) begin
      @(negedge clk);
      if (n >= LAT - 1) checkEq("R9", cipherOut, refEncrypt(plainIn, keyIn));
    end

    // asynchronous reset mid-cycle, then restart
    #1 rst = 1'b1;
    #0.5;
    checkEq("R4", cipherOut, '0);
    @(negedge clk);
    checkEq("R4", cipherOut, '0);
    rst = 1'b0;
    for (int n = 3; n < 3 + NTAIL; n++) begin
      vPt[n-3]  = vPt[n] ^ 128'h1;
      vKey[n-3] = vKey[n];
      vExp[n-3] = refEncrypt(vPt[n-3], vKey[n-3]);
      vReq[n-3] = "R2";
    end
    runStream(NTAIL);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule